// File: doc/BRIEF.md
# MII Receive Status and Framing Generator

This block sits on the PHY side of a media-independent interface and turns an abstract line view into the status and framing signals a MAC expects. The line side supplies an activity flag, one received nibble per clock and a per-nibble flag that marks an undecodable symbol. The MAC side supplies its transmit enable, transmit error and transmit nibble. From these the block derives carrier sense and collision, a registered receive stream with its valid and error strobes, and a transmit symbol choice between the MAC's data and a halt code.

Carrier sense and collision follow duplex mode. In half duplex, the block's own transmission also counts as carrier, and transmitting while receiving is a collision. In full duplex, transmission alone raises neither. Both outputs are combinational.

The receive stream has two framings selected by a speed input. At 100 Mb/s every nibble of the burst, preamble included, is forwarded, and invalid symbols are replaced by an error code. At 10 Mb/s the preamble is removed and the stream starts at the low nibble of the start-of-frame delimiter. The delimiter is recognised as a 0x5 nibble immediately followed by a 0xD nibble. To see the 0xD before it commits to the 0x5, the receive path holds one nibble of lookahead, so the receive outputs lag the line by two clocks at both speeds.

Top module: `mii_phy_status`

## Requirements
- R1: `crs` is high whenever `line_active` is high, in either duplex mode.
- R2: With `full_duplex` low, `crs` is also high whenever `tx_en` is high. With `full_duplex` high, `tx_en` alone leaves `crs` low.
- R3: `col` is high exactly when `line_active` and `tx_en` are both high and `full_duplex` is low, so it never rises in full duplex.
- R4: `crs`, `col`, `tx_halt_sel` and `tx_nibble` respond to their inputs within the same cycle, with no clock edge needed.
- R5: With `speed_100` high, the receive outputs two clock edges after a line sample equal that sample: `rx_dv` = `line_active`, and `rxd` = `line_nibble` while active. Preamble nibbles are included.
- R6: With `speed_100` high, a sample taken with `line_bad` high and `line_active` high gives `rx_er` = 1 and `rxd` = 4'b1110 two edges later.
- R7: With `speed_100` low, preamble nibbles are withheld. `rx_dv` first rises with `rxd` = 4'h5, the first nibble of the 0x5-then-0xD delimiter. The following outputs carry 4'hD and then the data nibbles, each two edges after its line sample.
- R8: With `speed_100` low, a burst that ends without a 0x5 nibble directly followed by a 0xD nibble never raises `rx_dv`.
- R9: With `speed_100` low, `line_bad` is ignored: `rx_er` stays low and `rxd` carries the received nibble unchanged.
- R10: Two clock edges after a sample with `line_active` low, `rx_dv`, `rx_er` and `rxd` are all zero.
- R11: `tx_halt_sel` = `tx_en` & `tx_er`. `tx_nibble` equals `txd` when `tx_en` is high and `tx_er` is low, and is zero otherwise.
- R12: A synchronous active-high `rst` zeroes `rx_dv`, `rx_er` and `rxd` after the next edge and returns the delimiter search to its hunting state. A 10 Mb/s burst interrupted by reset therefore stays invalid until a new delimiter arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_100 | input | 1 | 1 = 100 Mb/s framing, 0 = 10 Mb/s framing |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| line_active | input | 1 | Receive activity on the line |
| line_nibble | input | 4 | Received nibble |
| line_bad | input | 1 | Received nibble came from an invalid symbol |
| tx_en | input | 1 | MAC transmit enable |
| tx_er | input | 1 | MAC transmit error |
| txd | input | 4 | MAC transmit nibble |
| crs | output | 1 | Carrier sense (combinational) |
| col | output | 1 | Collision (combinational) |
| rx_dv | output | 1 | Receive data valid (registered) |
| rxd | output | 4 | Receive nibble (registered) |
| rx_er | output | 1 | Receive error (registered) |
| tx_halt_sel | output | 1 | 1 = send the halt symbol instead of data |
| tx_nibble | output | 4 | Data nibble for the symbol encoder |

## Verification
On every cycle the assertions check the following invariants:
- line activity implies carrier;
- full duplex forbids collision, and forbids carrier from transmission alone;
- a raised error strobe always comes with the error code;
- at 10 Mb/s the error strobe stays low and a rising valid always presents the delimiter's 0x5 nibble;
- the outputs clear one edge after the pipeline stage goes inactive, or after reset.

Some properties only the bench's sweeps can show. These are that the forwarded stream matches the line nibble for nibble, that the preamble is removed at every length tried, and that bursts without a delimiter stay invalid. They also include that a reset in mid-frame suppresses the remainder of the burst.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    localparam nib_t ERR_NIB = 4'b1110;
    localparam nib_t DELIM_A = 4'h5;
    localparam nib_t DELIM_B = 4'hD;

    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_PASS = 1'b1
    } frame_st_e;

    // one line sample
    typedef struct packed {
        logic vld;
        logic bad;
        nib_t nib;
    } rx_beat_t;

    // registered MAC-facing receive outputs
    typedef struct packed {
        logic dv;
        logic er;
        nib_t d;
    } mii_rx_t;

    // 100 Mb/s mapping: forward everything, substitute error code
    function automatic mii_rx_t map_fast(rx_beat_t b);
        mii_rx_t r;
        r.dv = b.vld;
        r.er = b.vld & b.bad;
        if (!b.vld)
            r.d = '0;
        else if (b.bad)
            r.d = ERR_NIB;
        else
            r.d = b.nib;
        return r;
    endfunction

    function automatic logic is_delim(nib_t first, nib_t second);
        return (first == DELIM_A) && (second == DELIM_B);
    endfunction

endpackage

// File: rtl/phy_rx_capture.sv
module phy_rx_capture
    import phy_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t cur,
    output rx_beat_t held
);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else
            held <= cur;
    end

endmodule

// File: rtl/phy_rx_framer.sv
module phy_rx_framer
    import phy_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     speed_100,
    input  rx_beat_t held,
    input  rx_beat_t cur,
    output mii_rx_t  q
);

    frame_st_e st, st_nxt;
    mii_rx_t   q_nxt;

    always_comb begin
        st_nxt = st;
        q_nxt  = '0;
        if (speed_100) begin
            q_nxt  = map_fast(held);
            st_nxt = FR_HUNT;
        end else begin
            unique case (st)
                FR_HUNT: begin
                    if (held.vld && cur.vld && is_delim(held.nib, cur.nib)) begin
                        q_nxt.dv = 1'b1;
                        q_nxt.d  = held.nib;
                        st_nxt   = FR_PASS;
                    end
                end
                FR_PASS: begin
                    if (held.vld) begin
                        q_nxt.dv = 1'b1;
                        q_nxt.d  = held.nib;
                    end else begin
                        st_nxt = FR_HUNT;
                    end
                end
                default: st_nxt = FR_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FR_HUNT;
            q  <= '0;
        end else begin
            st <= st_nxt;
            q  <= q_nxt;
        end
    end

    // R6: error strobe always carries the error code
    a_r6_err_code: assert property (@(posedge clk) disable iff (rst)
        q.er |-> (q.d == ERR_NIB));

    // R10: inactive pipeline stage clears the outputs on the next edge
    a_r10_drop: assert property (@(posedge clk) disable iff (rst)
        !held.vld |=> (!q.dv && !q.er && q.d == '0));

    // R7: at 10 Mb/s valid rises only on the delimiter's first nibble
    a_r7_dv_on_delim: assert property (@(posedge clk) disable iff (rst)
        ($rose(q.dv) && !$past(speed_100)) |-> (q.d == DELIM_A));

    // R9: no error strobe at 10 Mb/s
    a_r9_no_err_slow: assert property (@(posedge clk) disable iff (rst)
        !$past(speed_100) |-> !q.er);

    // R12: reset clears the registered outputs
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/phy_carrier_col.sv
module phy_carrier_col
    import phy_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic full_duplex,
    input  logic line_active,
    input  logic tx_en,
    input  logic tx_er,
    input  nib_t txd,
    output logic crs,
    output logic col,
    output logic tx_halt_sel,
    output nib_t tx_nibble
);

    logic tx_counts;

    always_comb begin
        tx_counts   = tx_en & ~full_duplex;
        crs         = line_active | tx_counts;
        col         = line_active & tx_counts;
        tx_halt_sel = tx_en & tx_er;
        tx_nibble   = (tx_en && !tx_er) ? txd : '0;
    end

    // R1: receive activity always gives carrier
    a_r1_crs_rx: assert property (@(posedge clk) disable iff (rst)
        line_active |-> crs);

    // R2: full-duplex transmission alone gives no carrier
    a_r2_fd_tx_quiet: assert property (@(posedge clk) disable iff (rst)
        (full_duplex && !line_active) |-> !crs);

    // R3: no collision in full duplex
    a_r3_col_fd: assert property (@(posedge clk) disable iff (rst)
        full_duplex |-> !col);

    // R11: halt selection excludes a data nibble
    a_r11_halt_no_data: assert property (@(posedge clk) disable iff (rst)
        tx_halt_sel |-> (tx_nibble == '0));

endmodule

// File: rtl/mii_phy_status.sv
module mii_phy_status
    import phy_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       speed_100,
    input  logic       full_duplex,
    input  logic       line_active,
    input  logic [3:0] line_nibble,
    input  logic       line_bad,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [3:0] txd,
    output logic       crs,
    output logic       col,
    output logic       rx_dv,
    output logic [3:0] rxd,
    output logic       rx_er,
    output logic       tx_halt_sel,
    output logic [3:0] tx_nibble
);

    rx_beat_t cur_beat, held_beat;
    mii_rx_t  rx_q;

    always_comb begin
        cur_beat.vld = line_active;
        cur_beat.bad = line_bad;
        cur_beat.nib = line_nibble;
    end

    phy_rx_capture u_capture (
        .clk  (clk),
        .rst  (rst),
        .cur  (cur_beat),
        .held (held_beat)
    );

    phy_rx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .speed_100 (speed_100),
        .held      (held_beat),
        .cur       (cur_beat),
        .q         (rx_q)
    );

    phy_carrier_col u_carrier (
        .clk         (clk),
        .rst         (rst),
        .full_duplex (full_duplex),
        .line_active (line_active),
        .tx_en       (tx_en),
        .tx_er       (tx_er),
        .txd         (txd),
        .crs         (crs),
        .col         (col),
        .tx_halt_sel (tx_halt_sel),
        .tx_nibble   (tx_nibble)
    );

    assign rx_dv = rx_q.dv;
    assign rx_er = rx_q.er;
    assign rxd   = rx_q.d;

endmodule

// File: tb/test_mii_phy_status.sv
`timescale 1ns/1ps
module test_mii_phy_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_100 = 1'b0;
    logic       full_duplex = 1'b0;
    logic       line_active = 1'b0;
    logic [3:0] line_nibble = '0;
    logic       line_bad = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = '0;
    logic       crs, col, rx_dv, rx_er, tx_halt_sel;
    logic [3:0] rxd, tx_nibble;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mii_phy_status i_mii_phy_status (
        .clk(clk), .rst(rst), .speed_100(speed_100), .full_duplex(full_duplex),
        .line_active(line_active), .line_nibble(line_nibble), .line_bad(line_bad),
        .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .crs(crs), .col(col), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
        .tx_halt_sel(tx_halt_sel), .tx_nibble(tx_nibble)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] nib_at(input int j, input int pre, input bit sfd);
        if (!sfd || j <= pre) return 4'h5;
        if (j == pre + 1) return 4'hD;
        return 4'((j * 7 + 3) & 15);
    endfunction

    // one burst: pre preamble nibbles, delimiter 5,D (or all 5s), 6 data nibbles
    task automatic run_frame(input bit spd, input int pre, input bit sfd, input int badpos);
        int total;
        total = pre + 2 + 6;
        speed_100 = spd;
        for (int j = 0; j <= total + 2; j++) begin
            line_active = (j < total);
            line_nibble = (j < total) ? nib_at(j, pre, sfd) : 4'h0;
            line_bad    = (j == badpos);
            tick();
            if (j >= 1) begin
                int k;
                bit act_k, bad_k, e_dv, e_er;
                logic [3:0] e_d;
                k = j - 1;
                act_k = (k < total);
                bad_k = (k == badpos);
                if (spd) begin
                    e_dv = act_k;
                    e_er = act_k && bad_k;
                    e_d  = !act_k ? 4'h0 : (bad_k ? 4'b1110 : nib_at(k, pre, sfd));
                    chk(rx_dv == e_dv, act_k ? "R5 dv" : "R10 dv", rx_dv, e_dv);
                    chk(rx_er == e_er, "R6 er", rx_er, e_er);
                    chk(rxd == e_d, bad_k ? "R6 rxd" : "R5 rxd", rxd, e_d);
                end else begin
                    e_dv = act_k && sfd && (k >= pre);
                    e_d  = e_dv ? nib_at(k, pre, sfd) : 4'h0;
                    chk(rx_dv == e_dv, sfd ? "R7 dv" : "R8 dv", rx_dv, e_dv);
                    chk(rx_er == 1'b0, "R9 er", rx_er, 0);
                    chk(rxd == e_d, bad_k ? "R9 rxd" : "R7 rxd", rxd, e_d);
                end
            end
        end
        line_bad = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R12: reset state
        chk(rx_dv == 0, "R12 dv", rx_dv, 0);
        chk(rx_er == 0, "R12 er", rx_er, 0);
        chk(rxd == 0, "R12 rxd", rxd, 0);
        rst = 1'b0;
        tick();

        // R1 R2 R3 R4: combinational sweep, no clock edge between set and check
        for (int m = 0; m < 8; m++) begin
            bit a, t, fd, e_crs, e_col;
            a = m[0]; t = m[1]; fd = m[2];
            @(negedge clk);
            line_active = a; tx_en = t; full_duplex = fd;
            #0.5;
            e_crs = a || (t && !fd);
            e_col = a && t && !fd;
            chk(crs == e_crs, a ? "R1 crs" : "R2 crs", crs, e_crs);
            chk(col == e_col, "R3 col", col, e_col);
        end
        // R11 R4: transmit selector sweep
        for (int m = 0; m < 64; m++) begin
            bit e_h;
            logic [3:0] e_n;
            @(negedge clk);
            tx_en = m[0]; tx_er = m[1]; txd = 4'(m >> 2);
            #0.5;
            e_h = m[0] && m[1];
            e_n = (m[0] && !m[1]) ? 4'(m >> 2) : 4'h0;
            chk(tx_halt_sel == e_h, "R11 halt", tx_halt_sel, e_h);
            chk(tx_nibble == e_n, "R11 nibble", tx_nibble, e_n);
        end
        @(negedge clk);
        line_active = 0; tx_en = 0; tx_er = 0; full_duplex = 0;
        tick(); tick();

        // R5..R10: framing sweep over speed, preamble length, delimiter, bad nibble
        for (int spd = 0; spd < 2; spd++)
            for (int pre = 0; pre < 8; pre++)
                for (int sfd = 0; sfd < 2; sfd++)
                    for (int b = 0; b < 2; b++)
                        run_frame(spd[0], pre, sfd[0], b ? pre + 3 : -1);

        // R12: reset mid-frame at 10 Mb/s, then resume without delimiter
        speed_100 = 1'b0;
        for (int j = 0; j < 6; j++) begin
            line_active = 1'b1;
            line_nibble = nib_at(j, 2, 1'b1);
            tick();
        end
        chk(rx_dv == 1, "R7 dv before reset", rx_dv, 1);
        rst = 1'b1;
        line_nibble = 4'hA;
        tick();
        chk(rx_dv == 0, "R12 dv mid-frame", rx_dv, 0);
        chk(rxd == 0, "R12 rxd mid-frame", rxd, 0);
        rst = 1'b0;
        for (int j = 0; j < 5; j++) begin
            line_nibble = 4'hA;
            tick();
            chk(rx_dv == 0, "R12 dv after reset", rx_dv, 0);
        end
        line_active = 1'b0;
        tick(); tick();
        chk(rx_dv == 0, "R10 dv idle", rx_dv, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule